// File: doc/BRIEF.md
# BCD Timekeeper with Shadow Registers

This block keeps calendar time in packed BCD counters that software cannot reach directly. It exposes eight byte-wide holding registers: one control byte and seven clock bytes. Whenever neither of the two access bits in the control byte is set, each new second is copied from the counters into the clock bytes. Software reads and writes the holding registers through a byte-wide write port and an addressed read port.

An input pulse `tick_in` drives a sub-second divider. Every `TICKS_PER_SEC` pulses make one second. The counters cover seconds, minutes and hours on a 24-hour clock, a day of week, the date, the month, a two-digit year and a century count. Month lengths and the leap-year rule are applied automatically.

To take a coherent snapshot, software sets the freeze bit, reads the bytes and then clears the bit. To set the clock, software sets the load bit, writes the clock bytes and then clears the bit. Clearing the load bit copies the bytes into the counters and restarts the divider. The low six bits of the control byte hold a calibration value: a sign bit and a five-bit magnitude. This value is stored and can be read back, but it does not act on the timebase.

Top module: `bcd_timekeeper`

## Requirements
- R1: Register selects: 0 = control, 1 = seconds, 2 = minutes, 3 = hours, 4 = day (weekday in bits [2:0], century count in bits [5:4]), 5 = date, 6 = month, 7 = year. After reset these read 00, 00, 00, 00, 01, 01, 01, 00 (hex).
- R2: After `TICKS_PER_SEC` tick pulses, seconds advance by one in BCD. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00 and carry into the day.
- R3: At midnight the weekday advances and wraps from 7 to 1.
- R4: The date wraps to 01 after the 30th in April, June, September and November. It wraps after the 31st in the other months, apart from February.
- R5: February ends on the 29th when the year value is a multiple of four, including year 00. Otherwise it ends on the 28th.
- R6: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century count, which wraps modulo four.
- R7: When control bits [7:6] are both 0, every new second overwrites clock bytes 1 to 7 with the counter values. A user write to a clock byte in this mode is stored and can be read back until that refresh, and it leaves the counters unchanged.
- R8: Control bit 6 (freeze) stops the refresh while the counters keep running. Clearing it refreshes the clock bytes on the next clock edge.
- R9: Control bit 7 (load) stops the refresh. Clearing it loads clock bytes 1 to 7 into the counters and clears the divider, so the next second comes after a further `TICKS_PER_SEC` pulses.
- R10: Control bits [5:0] (calibration sign in bit 5, magnitude in bits [4:0]) are stored and read back unchanged, and they do not change the tick count per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_in | input | 1 | One-cycle timebase pulse |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 3 | Holding register written |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Holding register read |
| rd_data | output | 8 | Read data of the selected holding register |

## Verification
A wrong counter shows at the ports no later than the next refresh. One second after the bad state, the clock bytes carry a wrong value or a wrong carry, so every date-rollover case is checked one second after a load. A wrong divider phase or a missed load shows as a second that arrives one or more pulses early or late. The bench therefore counts pulses exactly after each load release. A freeze or refresh fault shows in the same clock cycle as the control write, or one second later, depending on whether the clock bytes moved when they should have held.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;

    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned SEL_W    = $clog2(NUM_REGS);
    localparam int unsigned CTL_LOAD   = 7;
    localparam int unsigned CTL_FREEZE = 6;

    typedef logic [NUM_REGS-1:0][7:0] tk_bank_t;

    typedef struct packed {
        logic [1:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [2:0] wday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } tk_time_t;

    typedef struct packed {
        tk_bank_t bank;
        tk_time_t tm;
    } tk_state_t;

    localparam tk_time_t TK_RESET = '{cent: 2'd0, year: 8'h00, month: 8'h01,
                                      date: 8'h01, wday: 3'd1, hour: 8'h00,
                                      minute: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // multiple of four: (10*tens + ones) mod 4 == (2*tens + ones) mod 4
    function automatic logic is_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return s[1:0] == 2'd0;
    endfunction

    function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic tk_bank_t to_bytes(input tk_time_t t);
        tk_bank_t b;
        b    = '0;
        b[1] = {1'b0, t.sec[6:0]};
        b[2] = {1'b0, t.minute[6:0]};
        b[3] = {2'b0, t.hour[5:0]};
        b[4] = {2'b0, t.cent, 1'b0, t.wday};
        b[5] = {2'b0, t.date[5:0]};
        b[6] = {3'b0, t.month[4:0]};
        b[7] = t.year;
        return b;
    endfunction

    function automatic tk_time_t from_bytes(input tk_bank_t b);
        tk_time_t t;
        t.sec    = {1'b0, b[1][6:0]};
        t.minute = {1'b0, b[2][6:0]};
        t.hour   = {2'b0, b[3][5:0]};
        t.wday   = b[4][2:0];
        t.cent   = b[4][5:4];
        t.date   = {2'b0, b[5][5:0]};
        t.month  = {3'b0, b[6][4:0]};
        t.year   = b[7];
        return t;
    endfunction

endpackage

// File: rtl/bcd_tk_divider.sv
module bcd_tk_divider #(
    parameter int unsigned TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic clear,
    output logic sec_strobe
);
    localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign sec_strobe = tick_in && (cnt_q == LAST) && !clear;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick_in) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bcd_tk_advance.sv
module bcd_tk_advance
    import bcd_tk_pkg::*;
(
    input  tk_time_t cur,
    output tk_time_t nxt
);
    logic sec_wrap, min_wrap, hr_wrap, day_end, mon_wrap, yr_wrap;

    always_comb begin
        sec_wrap = cur.sec    == 8'h59;
        min_wrap = cur.minute == 8'h59;
        hr_wrap  = cur.hour   == 8'h23;
        day_end  = cur.date   == month_end(cur.month, cur.year);
        mon_wrap = cur.month  == 8'h12;
        yr_wrap  = cur.year   == 8'h99;

        nxt     = cur;
        nxt.sec = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
        if (sec_wrap) begin
            nxt.minute = min_wrap ? 8'h00 : bcd_inc(cur.minute);
            if (min_wrap) begin
                nxt.hour = hr_wrap ? 8'h00 : bcd_inc(cur.hour);
                if (hr_wrap) begin
                    nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    nxt.date = day_end ? 8'h01 : bcd_inc(cur.date);
                    if (day_end) begin
                        nxt.month = mon_wrap ? 8'h01 : bcd_inc(cur.month);
                        if (mon_wrap) begin
                            nxt.year = yr_wrap ? 8'h00 : bcd_inc(cur.year);
                            if (yr_wrap) nxt.cent = cur.cent + 2'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import bcd_tk_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_data
);
    tk_state_t st_d, st_q;
    tk_time_t  tm_next;
    tk_bank_t  fresh;
    tk_bank_t  bank_q;
    tk_time_t  tm_q;
    logic      sec_strobe;
    logic      ctl_wr, load_rel, frz_rel, refresh;

    assign ctl_wr   = wr_en && (wr_sel == SEL_W'(0));
    assign load_rel = ctl_wr && st_q.bank[0][CTL_LOAD] && !wr_data[CTL_LOAD];
    assign frz_rel  = ctl_wr && st_q.bank[0][CTL_FREEZE] && !wr_data[CTL_FREEZE];

    bcd_tk_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .clear      (load_rel),
        .sec_strobe (sec_strobe)
    );

    bcd_tk_advance i_advance (
        .cur (st_q.tm),
        .nxt (tm_next)
    );

    always_comb begin
        st_d = st_q;
        if (sec_strobe) st_d.tm = tm_next;
        if (wr_en) st_d.bank[wr_sel] = wr_data;
        if (load_rel) st_d.tm = from_bytes(st_q.bank);
        fresh   = to_bytes(st_d.tm);
        refresh = !load_rel && (st_d.bank[0][CTL_LOAD:CTL_FREEZE] == 2'b00)
                  && (sec_strobe || frz_rel);
        if (refresh) begin
            for (int i = 1; i < NUM_REGS; i++) begin
                if (!(wr_en && wr_sel == SEL_W'(i))) st_d.bank[i] = fresh[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tm   <= TK_RESET;
            st_q.bank <= to_bytes(TK_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.bank[rd_sel];
    assign bank_q  = st_q.bank;
    assign tm_q    = st_q.tm;
endmodule

// File: rtl/bcd_tk_checker.sv
module bcd_tk_checker
    import bcd_tk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sec_strobe,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [7:0]       wr_data,
    input tk_bank_t         bank,
    input tk_time_t         tm
);
    logic releasing;
    assign releasing = wr_en && (wr_sel == '0) && bank[0][7] && !wr_data[7];

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tm.sec <= 8'h59 && tm.sec[3:0] <= 4'd9); // R2
    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tm.hour <= 8'h23 && tm.hour[3:0] <= 4'd9); // R2
    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tm.wday >= 3'd1 && tm.wday <= 3'd7); // R3
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tm.date >= 8'h01 && tm.date <= 8'h31 && tm.month >= 8'h01 && tm.month <= 8'h12); // R4
    AST_TIME_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_strobe && !releasing) |=> $stable(tm)); // R9
    AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_strobe && !releasing) |=> tm.sec != $past(tm.sec)); // R2
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank[0][6] && !wr_en) |=> $stable(bank[7:1])); // R8
endmodule

bind bcd_timekeeper bcd_tk_checker i_bcd_tk_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_strobe (sec_strobe),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .bank       (bank_q),
    .tm         (tm_q)
);

// File: tb/test_bcd_timekeeper.sv
module test_bcd_timekeeper;
    localparam int TPS = 4;
    localparam int NV  = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_timekeeper #(.TICKS_PER_SEC(TPS)) i_bcd_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // entry: start bytes for selects 1..7, then expected bytes one second later, then requirement number
    localparam logic [0:14][7:0] VECS [NV] = '{
        '{8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h11,8'h01,8'h01,8'h00, 8'd6}, // R6 R3
        '{8'h59,8'h59,8'h23,8'h32,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h33,8'h29,8'h02,8'h24, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h33,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h34,8'h01,8'h03,8'h24, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h03,8'h23, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h05,8'h30,8'h04,8'h23, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h05,8'h23, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h06,8'h31,8'h01,8'h23, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h02,8'h23, 8'd4}, // R4
        '{8'h09,8'h34,8'h12,8'h01,8'h15,8'h06,8'h23, 8'h10,8'h34,8'h12,8'h01,8'h15,8'h06,8'h23, 8'd2}, // R2
        '{8'h59,8'h59,8'h10,8'h01,8'h15,8'h06,8'h23, 8'h00,8'h00,8'h11,8'h01,8'h15,8'h06,8'h23, 8'd2}, // R2
        '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h02,8'h29,8'h04,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h30,8'h04,8'h23, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h37,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00, 8'd6}, // R6
        '{8'h59,8'h59,8'h23,8'h01,8'h30,8'h09,8'h23, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h10,8'h23, 8'd4}, // R4
        '{8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,8'h96, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h96, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h98, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h98, 8'd5}, // R5
        '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h12, 8'd5}  // R5
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        rd_sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic set_time(input logic [0:6][7:0] b);
        wr(3'd0, 8'h80);
        for (int i = 0; i < 7; i++) wr(3'(i + 1), b[i]);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] rst_exp [8];
        rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v); check("R1 reset", v, rst_exp[i]);
        end

        for (int n = 0; n < NV; n++) begin
            set_time(VECS[n][0:6]);
            ticks(TPS);
            for (int i = 0; i < 7; i++) begin
                rd(3'(i + 1), v);
                checks++;
                if (v !== VECS[n][7 + i]) begin
                    failures++;
                    $display("FAIL R%0d vector %0d sel %0d: got %h expected %h",
                             VECS[n][14], n, i + 1, v, VECS[n][7 + i]);
                end
            end
        end

        // R7: user write is held until refresh, counters untouched
        set_time('{8'h31, 8'h00, 8'h05, 8'h01, 8'h10, 8'h03, 8'h23});
        wr(3'd1, 8'h45);
        rd(3'd1, v); check("R7 user write visible", v, 8'h45);
        ticks(TPS);
        rd(3'd1, v); check("R7 refresh overwrites", v, 8'h32);

        // R8: freeze holds bytes, counters run, release refreshes at once
        wr(3'd0, 8'h40);
        ticks(TPS);
        rd(3'd1, v); check("R8 frozen", v, 8'h32);
        wr(3'd0, 8'h00);
        rd(3'd1, v); check("R8 release refresh", v, 8'h33);
        rd(3'd2, v); check("R8 minutes", v, 8'h00);
        ticks(TPS);
        rd(3'd1, v); check("R8 running", v, 8'h34);

        // R9: load mode holds written values, release loads and clears divider
        wr(3'd0, 8'h80);
        wr(3'd1, 8'h50);
        ticks(TPS);
        rd(3'd1, v); check("R9 no refresh", v, 8'h50);
        ticks(2);
        wr(3'd0, 8'h00);
        rd(3'd1, v); check("R9 loaded", v, 8'h50);
        ticks(TPS - 1);
        rd(3'd1, v); check("R9 divider cleared", v, 8'h50);
        ticks(1);
        rd(3'd1, v); check("R9 next second", v, 8'h51);

        // R10: calibration bits stored, timing unchanged
        wr(3'd0, 8'h2A);
        rd(3'd0, v); check("R10 readback", v, 8'h2A);
        ticks(TPS - 1);
        rd(3'd1, v); check("R10 no early second", v, 8'h51);
        ticks(1);
        rd(3'd1, v); check("R10 second on time", v, 8'h52);
        wr(3'd0, 8'h1F);
        rd(3'd0, v); check("R10 readback2", v, 8'h1F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule